// File: doc/BRIEF.md
# Four-Slot CRC Packet Validator

This block sits behind the receive front end of a tag reader. In each read slot, four tag messages arrive together, one from each minislot. The block checks each one independently. Every 36-bit message is split into a 20-bit packet and a trailing 16-bit check word. The check word is recomputed over the packet and compared with the received one.

The packet's top nibble is then overwritten with a status code: 0 when the check words agree and 2 when they disagree. A second stage reads that status code. For a clean packet it forwards the 16-bit tag ID. For a corrupt packet it forces the slot to zero, so the identification stage downstream never sees a damaged ID.

The four results leave the block together, with one valid pulse and one error flag per slot. The valid pulse comes a fixed two cycles after the input strobe. Outputs hold their last value between results.

Top module: `tag_pkt_validator`

## Requirements
- R1: Slot k of `in_msgs` occupies bits [k*36+35 : k*36]. Within a message, bits [35:32] are the status nibble, [31:16] the tag ID and [15:0] the received check word. Slot k of `out_ids` occupies bits [k*16+15 : k*16], and `out_err[k]` belongs to slot k.
- R2: The check word is recomputed over the 20 packet bits (35 down to 16), most significant bit first. It uses polynomial 0x1021 (a parameter), register preset 0xFFFF and no final inversion.
- R3: When the recomputed and received check words match, the slot outputs its 16-bit tag ID and its error flag is 0.
- R4: When they differ, the slot outputs 0x0000 and its error flag is 1.
- R5: The received status nibble is part of the checked packet and is replaced by the block's own code. A message with any status value and a matching check word is accepted, and its nibble never appears at the output.
- R6: The four slots are judged independently, and all four results are presented in the same cycle.
- R7: If `in_valid` is high in cycle n, `out_valid` is high in cycle n+2 with that group's results. `out_valid` is not high in cycle n+1.
- R8: While `out_valid` is low, `out_ids` and `out_err` keep their last values, whatever `in_msgs` carries.
- R9: Synchronous active-high `rst` clears `out_valid`, `out_ids`, `out_err` and any group still in flight.
- R10: Groups strobed in consecutive cycles come out in consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Loads the four messages on `in_msgs` |
| in_msgs | input | 144 | Four 36-bit received messages, slot 0 in the low bits |
| out_valid | output | 1 | One-cycle pulse marking a new result group |
| out_ids | output | 64 | Four 16-bit IDs (zero for a rejected slot), slot 0 in the low bits |
| out_err | output | 4 | Per-slot check-word mismatch flag |

## Verification
The checker assumes that `in_valid` is a known 0 or 1 on every edge once reset is released. It also assumes that reset is held for at least one rising edge before the first strobe. Its latency reference is its own two-stage shift of `in_valid`, cleared by the same reset.

The stimulus meets these assumptions. It holds `rst` high for several edges with `in_valid` at 0. After that it changes inputs only on falling clock edges and always drives `in_valid` to a definite level. Junk is placed on `in_msgs` only while `in_valid` is low, which is the situation the hold property covers.

// File: rtl/tpv_pkg.sv
package tpv_pkg;

  // Width of the status field carried in the packet's top nibble.
  localparam int unsigned STAT_W = 4;

  // Status codes written into a packet after its check word is compared.
  typedef enum logic [STAT_W-1:0] {
    ST_GOOD = 4'd0,
    ST_BAD  = 4'd2
  } pkt_status_e;

endpackage

// File: rtl/tpv_crc_engine.sv
// Fully unrolled LFSR: one XOR/shift step per data bit, MSB first.
module tpv_crc_engine #(
  parameter int unsigned         DATA_W = 20,
  parameter int unsigned         CRC_W  = 16,
  parameter logic [CRC_W-1:0]    POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]    INIT   = 16'hFFFF
) (
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);

  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = INIT;

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic fb;
    assign fb           = chain[i][CRC_W-1] ^ data[DATA_W-1-i];
    assign chain[i+1]   = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc = chain[DATA_W];

endmodule

// File: rtl/tpv_slot_check.sv
// Stage 1 for one minislot: split, recompute, compare, stamp the status.
module tpv_slot_check
  import tpv_pkg::*;
#(
  parameter int unsigned      ID_W  = 16,
  parameter int unsigned      CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021,
  parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load,
  input  logic [STAT_W+ID_W+CRC_W-1:0]    msg,
  output logic [STAT_W+ID_W-1:0]          stamped_q
);

  localparam int unsigned PKT_W = STAT_W + ID_W;
  localparam int unsigned MSG_W = PKT_W + CRC_W;

  logic [PKT_W-1:0] pkt;
  logic [CRC_W-1:0] rx_crc;
  logic [CRC_W-1:0] calc_crc;
  logic             match;
  logic [PKT_W-1:0] stamped_d;

  assign pkt    = msg[MSG_W-1:CRC_W];
  assign rx_crc = msg[CRC_W-1:0];

  tpv_crc_engine #(
    .DATA_W (PKT_W),
    .CRC_W  (CRC_W),
    .POLY   (POLY),
    .INIT   (INIT)
  ) u_crc (
    .data (pkt),
    .crc  (calc_crc)
  );

  assign match     = (calc_crc == rx_crc);
  assign stamped_d = {(match ? ST_GOOD : ST_BAD), pkt[ID_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      stamped_q <= '0;
    end else if (load) begin
      stamped_q <= stamped_d;
    end
  end

endmodule

// File: rtl/tpv_status_gate.sv
// Stage 2 for one minislot: read the status, strip it, zero a bad slot.
module tpv_status_gate
  import tpv_pkg::*;
#(
  parameter int unsigned ID_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [STAT_W+ID_W-1:0]   stamped,
  output logic [ID_W-1:0]          id_q,
  output logic                     err_q
);

  logic [STAT_W-1:0] status;
  logic              bad;

  assign status = stamped[STAT_W+ID_W-1:ID_W];
  assign bad    = (status != ST_GOOD);

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= '0;
      err_q <= 1'b0;
    end else if (load) begin
      id_q  <= bad ? '0 : stamped[ID_W-1:0];
      err_q <= bad;
    end
  end

endmodule

// File: rtl/tag_pkt_validator.sv
module tag_pkt_validator
  import tpv_pkg::*;
#(
  parameter int unsigned      NUM_SLOTS = 4,
  parameter int unsigned      ID_W      = 16,
  parameter int unsigned      CRC_W     = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      in_valid,
  input  logic [NUM_SLOTS*(STAT_W+ID_W+CRC_W)-1:0]  in_msgs,
  output logic                                      out_valid,
  output logic [NUM_SLOTS*ID_W-1:0]                 out_ids,
  output logic [NUM_SLOTS-1:0]                      out_err
);

  localparam int unsigned PKT_W = STAT_W + ID_W;
  localparam int unsigned MSG_W = PKT_W + CRC_W;

  logic stage1_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_v  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      stage1_v  <= in_valid;
      out_valid <= stage1_v;
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [PKT_W-1:0] stamped;

    tpv_slot_check #(
      .ID_W  (ID_W),
      .CRC_W (CRC_W),
      .POLY  (CRC_POLY),
      .INIT  (CRC_INIT)
    ) u_check (
      .clk       (clk),
      .rst       (rst),
      .load      (in_valid),
      .msg       (in_msgs[k*MSG_W +: MSG_W]),
      .stamped_q (stamped)
    );

    tpv_status_gate #(
      .ID_W (ID_W)
    ) u_gate (
      .clk     (clk),
      .rst     (rst),
      .load    (stage1_v),
      .stamped (stamped),
      .id_q    (out_ids[k*ID_W +: ID_W]),
      .err_q   (out_err[k])
    );
  end

endmodule

// File: rtl/tpv_checker.sv
module tpv_checker #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ID_W      = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      out_valid,
  input logic [NUM_SLOTS*ID_W-1:0] out_ids,
  input logic [NUM_SLOTS-1:0]      out_err
);

  logic v1, v2, past_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) past_rst <= rst;

  // R7: result pulse two cycles after the strobe
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid == v2);

  // R8: outputs frozen between results
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !past_rst) |-> ($stable(out_ids) && $stable(out_err)));

  // R4: a flagged slot carries zero
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_zero
    p_zero_bad_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_err[k]) |-> (out_ids[k*ID_W +: ID_W] == '0));
  end

  // R9: everything cleared after a reset edge
  always @(negedge clk) begin
    if (past_rst === 1'b1) begin
      p_reset_clear_r9: assert (out_valid == 1'b0 && out_ids == '0 && out_err == '0);
    end
  end

endmodule

bind tag_pkt_validator tpv_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .ID_W      (ID_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_ids   (out_ids),
  .out_err   (out_err)
);

// File: tb/sim_tag_pkt_validator.sv
`timescale 1ns/1ps
module sim_tag_pkt_validator;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [143:0] in_msgs;
  logic         out_valid;
  logic [63:0]  out_ids;
  logic [3:0]   out_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  tag_pkt_validator u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_msgs   (in_msgs),
    .out_valid (out_valid),
    .out_ids   (out_ids),
    .out_err   (out_err)
  );

  // Row r: IDs of slots 3..0 (slot 0 low), and which slots get one bit flipped.
  localparam logic [63:0] V_IDS [8] = '{
    64'hEA60_0010_0005_00C8,
    64'h1FC8_18E0_0F90_03E5,
    64'h7FFE_8001_0000_FFFF,
    64'hDEF0_9ABC_5678_1234,
    64'hF0F0_0F0F_5555_AAAA,
    64'h0008_0004_0002_0001,
    64'hFACE_BEEF_C0DE_4B1D,
    64'h0BD1_ACE0_1357_2468
  };
  localparam logic [3:0] V_BAD [8] = '{
    4'b0000, 4'b0001, 4'b1010, 4'b1111, 4'b0100, 4'b1000, 4'b0110, 4'b0000
  };

  // R2: reference check word, bit-serial, MSB first
  function automatic logic [15:0] ref_crc(input logic [19:0] p);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int i = 19; i >= 0; i--) begin
      if (r[15] ^ p[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [35:0] make_msg(input logic [3:0] st, input logic [15:0] id);
    return {st, id, ref_crc({st, id})};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Strobe one group and check it two cycles later (R7).
  task automatic send_check(input string tag, input logic [143:0] m,
                            input logic [63:0] eid, input logic [3:0] eerr);
    @(negedge clk);
    in_msgs  = m;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R7 not early"}, {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk({tag, " R7 valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " R1 R3 R6 ids"}, out_ids, eid);
    chk({tag, " R4 err"}, {60'd0, out_err}, {60'd0, eerr});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [143:0] m, ma, mb;
    logic [63:0]  eid, eida, eidb, held_ids;
    logic [3:0]   eerr, eerra, eerrb, held_err;
    logic [35:0]  one;
    logic [15:0]  id;
    int           pos;

    rst      = 1'b1;
    in_valid = 1'b0;
    in_msgs  = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset ids",   out_ids, 64'd0);
    chk("R9 reset err",   {60'd0, out_err}, 64'd0);
    chk("R9 reset valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;

    // Vector table: good packets and single-bit corruptions (R2 R3 R4 R6)
    for (int r = 0; r < 8; r++) begin
      m = '0; eid = '0; eerr = '0;
      for (int s = 0; s < 4; s++) begin
        id  = V_IDS[r][s*16 +: 16];
        one = make_msg(4'h0, id);
        if (V_BAD[r][s]) begin
          pos      = (r*7 + s*11) % 36;
          one[pos] = ~one[pos];
          eerr[s]  = 1'b1;
        end else begin
          eid[s*16 +: 16] = id;
        end
        m[s*36 +: 36] = one;
      end
      send_check($sformatf("row%0d R2", r), m, eid, eerr);
    end

    // R5: received status nibble is checked, then replaced
    m = '0;
    m[0*36 +: 36] = make_msg(4'h5, 16'h1111);
    m[1*36 +: 36] = make_msg(4'h2, 16'h2222);
    m[2*36 +: 36] = make_msg(4'hF, 16'h3333);
    one = make_msg(4'h0, 16'h4444);
    one[35:32] = 4'h1;
    m[3*36 +: 36] = one;
    send_check("R5 status nibble", m, 64'h0000_3333_2222_1111, 4'b1000);

    // R4 all-zero messages: preset makes zero check word a mismatch
    eerr = (ref_crc(20'd0) != 16'd0) ? 4'b1111 : 4'b0000;
    send_check("R4 all zero", '0, 64'd0, eerr);

    // R8: outputs hold while idle input changes
    m = '0;
    m[0*36 +: 36] = make_msg(4'h0, 16'hBEAD);
    m[1*36 +: 36] = make_msg(4'h0, 16'h0F0F);
    m[2*36 +: 36] = make_msg(4'h0, 16'hC3C3) ^ 36'h1;
    m[3*36 +: 36] = make_msg(4'h0, 16'h7777);
    send_check("R8 setup", m, 64'h7777_0000_0F0F_BEAD, 4'b0100);
    held_ids = out_ids;
    held_err = out_err;
    for (int i = 0; i < 4; i++) begin
      in_msgs = {16{9'h1A5}} ^ {i[15:0], 128'd0};
      @(negedge clk);
      chk("R8 hold valid", {63'd0, out_valid}, 64'd0);
      chk("R8 hold ids", out_ids, held_ids);
      chk("R8 hold err", {60'd0, out_err}, {60'd0, held_err});
    end

    // R10: back-to-back groups
    ma = '0; mb = '0; eida = '0; eidb = '0; eerra = 4'b0010; eerrb = 4'b0001;
    for (int s = 0; s < 4; s++) begin
      ma[s*36 +: 36] = make_msg(4'h0, 16'hA000 + 16'(s));
      mb[s*36 +: 36] = make_msg(4'h0, 16'hB000 + 16'(s));
      if (s != 1) eida[s*16 +: 16] = 16'hA000 + 16'(s);
      if (s != 0) eidb[s*16 +: 16] = 16'hB000 + 16'(s);
    end
    ma[1*36 +: 36] = ma[1*36 +: 36] ^ 36'h0_0000_8000;
    mb[0*36 +: 36] = mb[0*36 +: 36] ^ 36'h0_8000_0000;
    @(negedge clk);
    in_msgs = ma; in_valid = 1'b1;
    @(negedge clk);
    in_msgs = mb;
    @(negedge clk);
    chk("R10 first valid", {63'd0, out_valid}, 64'd1);
    chk("R10 first ids", out_ids, eida);
    chk("R10 first err", {60'd0, out_err}, {60'd0, eerra});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 second valid", {63'd0, out_valid}, 64'd1);
    chk("R10 second ids", out_ids, eidb);
    chk("R10 second err", {60'd0, out_err}, {60'd0, eerrb});
    @(negedge clk);
    chk("R10 pulse ends", {63'd0, out_valid}, 64'd0);

    // R9: reset discards a group in flight
    @(negedge clk);
    in_msgs = ma; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R9 mid ids",   out_ids, 64'd0);
    chk("R9 mid err",   {60'd0, out_err}, 64'd0);
    chk("R9 mid valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 no stale valid", {63'd0, out_valid}, 64'd0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule